// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface and walks the memory from power-up to its operating state. After reset is released it keeps the command pins at NOP for a stabilization interval. It then precharges every bank, issues two auto-refresh commands and finally programs the mode register with a word built from its configuration inputs. Each command is followed by NOP cycles that cover that command's recovery time. All waits are parameters expressed in clock cycles. The stabilization interval is the product of the clock frequency in MHz and the hold time in microseconds.

Once the mode-register recovery time has elapsed, `init_done` goes high and stays high until the next reset. A downstream controller takes over the pins from then on. CKE is driven high throughout, so the memory never enters power-down while it is being initialized. The configuration inputs are expected to be held stable while the sequence runs.

Top module: `sdram_init_seq`

## Requirements
- R1: While rst_n is low the outputs show a NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), addr and ba are zero, init_done is low and cke is high.
- R2: For the first HOLD_CYC = CLK_MHZ*POWERUP_US cycles after reset release (cycles 0 to HOLD_CYC-1), only NOP is driven, with addr and ba zero.
- R3: In cycle HOLD_CYC a precharge-all is driven (cs_n=0, ras_n=0, cas_n=1, we_n=0), with addr bit AP_BIT (A10) high, every other addr bit zero and ba zero.
- R4: Auto-refresh (cs_n=0, ras_n=0, cas_n=0, we_n=1, addr and ba zero) is driven exactly twice: T_RP cycles after the precharge, and again T_RFC cycles after the first refresh.
- R5: The mode register load (cs_n, ras_n, cas_n and we_n all 0, ba zero) is driven exactly once, T_RFC cycles after the second refresh, and never before both refreshes.
- R6: The loaded word has addr[2:0]=cfg_burst_len, addr[3]=cfg_burst_type, addr[6:4]=cfg_cas_lat and addr[9]=cfg_wr_single, with addr[8:7], addr[11:10] and every bit from 12 upward zero.
- R7: Every cycle between two commands of the sequence carries a NOP with addr and ba zero.
- R8: init_done rises exactly T_MRD cycles after the mode register load and then stays high with NOP on the pins until reset.
- R9: cke is high in every cycle, both in reset and after it.
- R10: Asserting reset in the middle of the sequence abandons it, and after release the whole sequence restarts from the stabilization hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst_len | input | 3 | Burst length code placed in mode bits 2..0 |
| cfg_burst_type | input | 1 | Burst type placed in mode bit 3 |
| cfg_cas_lat | input | 3 | CAS latency code placed in mode bits 6..4 |
| cfg_wr_single | input | 1 | Write burst mode placed in mode bit 9 |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| ba | output | BA_W | Bank address bus |
| init_done | output | 1 | High once initialization is complete |

## Verification
The assertions assume that every wait parameter is at least one cycle and that the configuration inputs do not change while the sequence is running. That is why the mode-word property compares the loaded word only against fields that are held steady. The bench draws each configuration from a seeded random source and sets it before reset is released. It holds the configuration until the next reset and adds all-zero and all-one configurations as directed corners. One trial pulls reset partway through the sequence, so that the restart is checked in the middle of a run.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

   typedef enum logic [2:0] {
      PH_HOLD = 3'd0,
      PH_PRE  = 3'd1,
      PH_REF1 = 3'd2,
      PH_REF2 = 3'd3,
      PH_MRS  = 3'd4,
      PH_DONE = 3'd5
   } phase_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } cmd_t;

   localparam cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
   localparam cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
   localparam cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
   localparam cmd_t CMD_MRS = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

   function automatic phase_e phase_succ(input phase_e p);
      case (p)
         PH_HOLD: return PH_PRE;
         PH_PRE:  return PH_REF1;
         PH_REF1: return PH_REF2;
         PH_REF2: return PH_MRS;
         default: return PH_DONE;
      endcase
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
   parameter int CNT_W   = 8,
   parameter int RST_VAL = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= CNT_W'(RST_VAL);
      end else if (load) begin
         count_q <= load_val;
      end else if (count_q != '0) begin
         count_q <= count_q - 1'b1;
      end
   end

   assign expired = (count_q == '0);

   // Once expired, the count stays at zero until a new length is loaded.
   p_expired_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !load) |=> expired);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
   import sdram_init_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int HOLD_CYC = 100,
   parameter int T_RP     = 2,
   parameter int T_RFC    = 8,
   parameter int T_MRD    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             expired,
   output logic             load,
   output logic [CNT_W-1:0] load_val,
   output phase_e           phase,
   output logic             first
);

   phase_e phase_q;
   logic   first_q;
   phase_e phase_nx;

   // The length of a phase is how long it holds before the next command may follow.
   function automatic logic [CNT_W-1:0] phase_len_m1(input phase_e p);
      case (p)
         PH_HOLD: return CNT_W'(HOLD_CYC - 1);
         PH_PRE:  return CNT_W'(T_RP - 1);
         PH_REF1: return CNT_W'(T_RFC - 1);
         PH_REF2: return CNT_W'(T_RFC - 1);
         PH_MRS:  return CNT_W'(T_MRD - 1);
         default: return '0;
      endcase
   endfunction

   always_comb begin
      phase_nx = phase_succ(phase_q);
      load     = (phase_q != PH_DONE) && expired;
      load_val = phase_len_m1(phase_nx);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_HOLD;
         first_q <= 1'b0;
      end else if (load) begin
         phase_q <= phase_nx;
         first_q <= 1'b1;
      end else begin
         first_q <= 1'b0;
      end
   end

   assign phase = phase_q;
   assign first = first_q;

   // Phases advance only one step at a time, in the fixed order.
   p_phase_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(phase_q) |-> (phase_q == phase_succ($past(phase_q))));

   // The done phase is never left without a reset.
   p_done_final_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DONE) |=> (phase_q == PH_DONE));

endmodule

// File: rtl/sdram_mode_word.sv
module sdram_mode_word #(
   parameter int ADDR_W = 13
) (
   input  logic [2:0]        burst_len,
   input  logic              burst_type,
   input  logic [2:0]        cas_lat,
   input  logic              wr_single,
   output logic [ADDR_W-1:0] word
);

   localparam int CORE_W = 12;

   logic [CORE_W-1:0] core;

   always_comb begin
      core        = '0;
      core[2:0]   = burst_len;
      core[3]     = burst_type;
      core[6:4]   = cas_lat;
      core[8:7]   = 2'b00;
      core[9]     = wr_single;
      core[11:10] = 2'b00;
   end

   generate
      if (ADDR_W > CORE_W) begin : g_wide
         assign word = {{(ADDR_W-CORE_W){1'b0}}, core};
      end else begin : g_exact
         assign word = core;
      end
   endgenerate

endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
   import sdram_init_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int BA_W   = 2,
   parameter int AP_BIT = 10
) (
   input  phase_e            phase,
   input  logic              first,
   input  logic [ADDR_W-1:0] mode_word,
   output cmd_t              cmd,
   output logic [ADDR_W-1:0] addr,
   output logic [BA_W-1:0]   ba,
   output logic              done
);

   localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

   always_comb begin
      cmd  = CMD_NOP;
      addr = '0;
      ba   = '0;
      if (first) begin
         case (phase)
            PH_PRE: begin
               cmd  = CMD_PRE;
               addr = AP_MASK;
            end
            PH_REF1, PH_REF2: cmd = CMD_REF;
            PH_MRS: begin
               cmd  = CMD_MRS;
               addr = mode_word;
            end
            default: cmd = CMD_NOP;
         endcase
      end
      done = (phase == PH_DONE);
   end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
   import sdram_init_pkg::*;
#(
   parameter int CLK_MHZ    = 100,
   parameter int POWERUP_US = 100,
   parameter int T_RP       = 3,
   parameter int T_RFC      = 8,
   parameter int T_MRD      = 2,
   parameter int ADDR_W     = 13,
   parameter int BA_W       = 2,
   parameter int AP_BIT     = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cfg_burst_len,
   input  logic              cfg_burst_type,
   input  logic [2:0]        cfg_cas_lat,
   input  logic              cfg_wr_single,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [ADDR_W-1:0] addr,
   output logic [BA_W-1:0]   ba,
   output logic              init_done
);

   localparam int HOLD_CYC = CLK_MHZ * POWERUP_US;
   localparam int MAX_T    = max_of(max_of(HOLD_CYC, T_RP), max_of(T_RFC, T_MRD));
   localparam int CNT_W    = $clog2(MAX_T + 2);

   generate
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("stabilization hold must be at least one cycle");
      end
      if (T_RP < 1 || T_RFC < 1 || T_MRD < 1) begin : g_bad_wait
         $error("command waits must be at least one cycle");
      end
      if (ADDR_W < 12) begin : g_bad_addr
         $error("address bus too narrow for the mode word");
      end
      if (AP_BIT >= ADDR_W) begin : g_bad_ap
         $error("all-bank bit outside the address bus");
      end
      if (BA_W < 1) begin : g_bad_ba
         $error("bank address needs at least one bit");
      end
   endgenerate

   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_expired;
   phase_e           phase;
   logic             first;
   logic [ADDR_W-1:0] mode_word;
   cmd_t             cmd;

   sdram_init_timer #(
      .CNT_W   (CNT_W),
      .RST_VAL (HOLD_CYC - 1)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   sdram_init_fsm #(
      .CNT_W    (CNT_W),
      .HOLD_CYC (HOLD_CYC),
      .T_RP     (T_RP),
      .T_RFC    (T_RFC),
      .T_MRD    (T_MRD)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .expired  (tmr_expired),
      .load     (tmr_load),
      .load_val (tmr_val),
      .phase    (phase),
      .first    (first)
   );

   sdram_mode_word #(
      .ADDR_W (ADDR_W)
   ) u_mode (
      .burst_len  (cfg_burst_len),
      .burst_type (cfg_burst_type),
      .cas_lat    (cfg_cas_lat),
      .wr_single  (cfg_wr_single),
      .word       (mode_word)
   );

   sdram_cmd_drive #(
      .ADDR_W (ADDR_W),
      .BA_W   (BA_W),
      .AP_BIT (AP_BIT)
   ) u_drive (
      .phase     (phase),
      .first     (first),
      .mode_word (mode_word),
      .cmd       (cmd),
      .addr      (addr),
      .ba        (ba),
      .done      (init_done)
   );

   assign cke   = 1'b1;
   assign cs_n  = cmd.cs_n;
   assign ras_n = cmd.ras_n;
   assign cas_n = cmd.cas_n;
   assign we_n  = cmd.we_n;

   // Checker state: cycles since the last command and refreshes seen so far.
   logic [CNT_W-1:0] since_cmd;
   logic [1:0]       ref_seen;
   logic             is_cmd;
   logic             is_ref;
   logic             is_mrs;

   assign is_cmd = ({cs_n, ras_n, cas_n, we_n} != CMD_NOP);
   assign is_ref = ({cs_n, ras_n, cas_n, we_n} == CMD_REF);
   assign is_mrs = ({cs_n, ras_n, cas_n, we_n} == CMD_MRS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_cmd <= '0;
         ref_seen  <= '0;
      end else begin
         if (is_cmd) begin
            since_cmd <= CNT_W'(1);
         end else if (since_cmd != '1) begin
            since_cmd <= since_cmd + 1'b1;
         end
         if (is_ref && ref_seen != 2'd3) begin
            ref_seen <= ref_seen + 1'b1;
         end
      end
   end

   p_ref_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      is_ref |-> (since_cmd == CNT_W'((ref_seen == 2'd0) ? T_RP : T_RFC)));

   p_two_ref_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      is_ref |-> (ref_seen < 2'd2));

   p_mrs_after_refs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      is_mrs |-> (ref_seen == 2'd2 && since_cmd == CNT_W'(T_RFC)));

   p_mrs_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
      is_mrs |-> (addr[8:7] == 2'b00 && addr[11:10] == 2'b00 && ba == '0));

   p_done_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> (since_cmd == CNT_W'(T_MRD)));

   p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> (init_done && !is_cmd));

   p_cmd_needs_clock_r9: assert property (@(posedge clk) disable iff (!rst_n)
      is_cmd |-> cke);

endmodule

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;

   localparam int CLK_PERIOD = 10;
   localparam int CLK_MHZ    = 1;
   localparam int POWERUP_US = 40;
   localparam int T_RP       = 3;
   localparam int T_RFC      = 6;
   localparam int T_MRD      = 2;
   localparam int ADDR_W     = 13;
   localparam int BA_W       = 2;
   localparam int HOLD       = CLK_MHZ * POWERUP_US;
   localparam int N_PRE      = HOLD;
   localparam int N_REF1     = N_PRE + T_RP;
   localparam int N_REF2     = N_REF1 + T_RFC;
   localparam int N_MRS      = N_REF2 + T_RFC;
   localparam int N_DONE     = N_MRS + T_MRD;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [2:0]        cfg_bl = '0;
   logic              cfg_bt = 1'b0;
   logic [2:0]        cfg_cl = '0;
   logic              cfg_wb = 1'b0;
   logic              cke, cs_n, ras_n, cas_n, we_n, init_done;
   logic [ADDR_W-1:0] addr;
   logic [BA_W-1:0]   ba;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdram_init_seq #(
      .CLK_MHZ    (CLK_MHZ),
      .POWERUP_US (POWERUP_US),
      .T_RP       (T_RP),
      .T_RFC      (T_RFC),
      .T_MRD      (T_MRD),
      .ADDR_W     (ADDR_W),
      .BA_W       (BA_W),
      .AP_BIT     (10)
   ) dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_burst_len  (cfg_bl),
      .cfg_burst_type (cfg_bt),
      .cfg_cas_lat    (cfg_cl),
      .cfg_wr_single  (cfg_wb),
      .cke            (cke),
      .cs_n           (cs_n),
      .ras_n          (ras_n),
      .cas_n          (cas_n),
      .we_n           (we_n),
      .addr           (addr),
      .ba             (ba),
      .init_done      (init_done)
   );

   // Packed observation: {cke, cs_n, ras_n, cas_n, we_n, init_done, ba, addr}
   localparam int OBS_W = 6 + BA_W + ADDR_W;

   function automatic logic [ADDR_W-1:0] exp_mode(input logic [2:0] bl, input logic bt,
                                                  input logic [2:0] cl, input logic wb);
      logic [ADDR_W-1:0] w;
      w      = '0;
      w[2:0] = bl;
      w[3]   = bt;
      w[6:4] = cl;
      w[9]   = wb;
      return w;
   endfunction

   function automatic logic [OBS_W-1:0] exp_obs(input int n, input logic [ADDR_W-1:0] mw);
      logic [3:0]        c;
      logic [ADDR_W-1:0] a;
      logic              d;
      c = 4'b0111;
      a = '0;
      d = (n >= N_DONE);
      if (n == N_PRE) begin
         c = 4'b0010;
         a[10] = 1'b1;
      end else if (n == N_REF1 || n == N_REF2) begin
         c = 4'b0001;
      end else if (n == N_MRS) begin
         c = 4'b0000;
         a = mw;
      end
      return {1'b1, c, d, {BA_W{1'b0}}, a};
   endfunction

   function automatic string req_of(input int n);
      if (n < N_PRE)       return "R2";
      if (n == N_PRE)      return "R3";
      if (n == N_REF1)     return "R4";
      if (n == N_REF2)     return "R4";
      if (n == N_MRS)      return "R6";
      if (n >= N_DONE)     return "R8";
      return "R7";
   endfunction

   function automatic logic [OBS_W-1:0] act_obs();
      return {cke, cs_n, ras_n, cas_n, we_n, init_done, ba, addr};
   endfunction

   task automatic check(input string req, input logic [OBS_W-1:0] act,
                        input logic [OBS_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic enter_reset();
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1", act_obs(), {1'b1, 4'b0111, 1'b0, {BA_W{1'b0}}, {ADDR_W{1'b0}}});
   endtask

   // Runs one sequence; stops early at abort_at if it is not negative.
   task automatic run_seq(input int abort_at, input string hold_tag);
      logic [ADDR_W-1:0] mw;
      bit                cke_low;
      int                last;
      mw      = exp_mode(cfg_bl, cfg_bt, cfg_cl, cfg_wb);
      cke_low = 1'b0;
      last    = (abort_at >= 0) ? abort_at : N_DONE + 6;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      for (int n = 0; n <= last; n++) begin
         string tag;
         tag = req_of(n);
         if (n < N_PRE && hold_tag != "") tag = hold_tag;
         if (n == N_MRS) tag = "R5/R6";
         if (cke !== 1'b1) cke_low = 1'b1;
         check(tag, act_obs(), exp_obs(n, mw));
         @(negedge clk);
         #1;
      end
      check("R9", {{(OBS_W-1){1'b0}}, cke_low}, '0);
   endtask

   task automatic set_cfg(input logic [2:0] bl, input logic bt, input logic [2:0] cl,
                          input logic wb);
      cfg_bl = bl;
      cfg_bt = bt;
      cfg_cl = cl;
      cfg_wb = wb;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      checks++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1: reset state, R9 cke high in reset
      enter_reset();

      // Directed corners: all-zero and all-one configurations (R6 reserved bits stay 0)
      set_cfg(3'b000, 1'b0, 3'b000, 1'b0);
      run_seq(-1, "");
      enter_reset();
      set_cfg(3'b111, 1'b1, 3'b111, 1'b1);
      run_seq(-1, "");

      // R10: reset between the refreshes, then a full restart
      enter_reset();
      set_cfg(3'b010, 1'b1, 3'b011, 1'b0);
      run_seq(N_REF2 - 1, "");
      enter_reset();
      run_seq(-1, "R10");

      // Constrained random configurations, held stable per sequence
      for (int t = 0; t < 5; t++) begin
         enter_reset();
         set_cfg(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
         run_seq(-1, "");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule